// File: doc/BRIEF.md
# SDRAM Low-Power Mode Sequencer

This block sits on the controller side of a two-bank SDR SDRAM. It takes the CKE and command pins away from the normal access path and moves the memory into or out of three states: self-refresh, power-down and clock suspend. Each low-power state is held for as long as the host keeps the matching request line high.

Before the block enters self-refresh it settles the memory. A read or write burst that is still running is ended with a burst stop, and the block waits out the CAS latency. Any open bank is closed with a precharge-all, and the block waits the precharge time. When self-refresh ends, the block waits a recovery interval and then issues a full, evenly spaced sweep of auto-refresh commands. Only after that does it hand the pins back.

Power-down and clock suspend do not refresh the array. Their residency is therefore capped by a timer. When the cap expires, the block forces an exit and stays out of both states until the host drops both requests.

While the block is idle, the host's command passes straight through and the grant is high. In every other state the grant is low.

Top module: `lp_seq`

## Requirements
- R1: While reset is asserted and when it is released, sd_cke is 1 and host_gnt is 1.
- R2: In the idle state host_gnt is 1, sd_cke is 1, and {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} and sd_a10 equal host_cmd and host_a10 in the same cycle.
- R3: Suppose sr_req is seen with burst_active low and no bank open. In the next cycle sd_cke drops to 0 with command 4'b0001 ({cs,ras,cas,we}), and host_gnt falls to 0.
- R4: Suppose self-refresh is requested while a bank is open. The block drives one precharge cycle (command 4'b0010 with sd_a10 = 1), then T_RP cycles of no-operation (4'b0111), and then enters self-refresh.
- R5: Suppose self-refresh is requested while burst_active is high. The block drives one burst-stop cycle (4'b0110), then CAS_LAT no-operation cycles, then continues with the precharge or the self-refresh entry.
- R6: sd_cke stays 0 for as long as sr_req is held.
- R7: In the cycle after any low-power request is released, sd_cke returns to 1. The block then drives no-operation for T_CKA cycles, with host_gnt still 0.
- R8: After the self-refresh recovery, the block issues exactly REF_COUNT auto-refresh commands (4'b0001 with sd_cke = 1). Each one is followed by T_RC no-operation cycles, and host_gnt returns to 1 in the cycle after the last wait cycle.
- R9: A pd_req seen in the idle state drops sd_cke to 0 with no-operation on the pins. The low state lasts until pd_req falls, and is followed by the R7 recovery and then the grant.
- R10: A power-down or clock-suspend residency lasts at most T_REF_LIM cycles, after which the block forces an exit. After a forced exit, neither state is re-entered until pd_req and cs_req have both been low.
- R11: cs_req takes effect only while burst_active is high. Otherwise sd_cke and host_gnt stay 1.
- R12: When several requests arrive together, self-refresh wins over clock suspend, and clock suspend wins over power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sr_req | input | 1 | Hold self-refresh while high |
| pd_req | input | 1 | Hold power-down while high |
| cs_req | input | 1 | Hold clock suspend while high |
| burst_active | input | 1 | A read or write burst is in flight |
| bank_open | input | BANKS | Per-bank open-row flags |
| host_cmd | input | 4 | Host command {cs_n, ras_n, cas_n, we_n} |
| host_a10 | input | 1 | Host A10 |
| host_gnt | output | 1 | Host owns the pins; new accesses allowed |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | SDRAM chip select |
| sd_ras_n | output | 1 | SDRAM row strobe |
| sd_cas_n | output | 1 | SDRAM column strobe |
| sd_we_n | output | 1 | SDRAM write enable |
| sd_a10 | output | 1 | SDRAM A10 (all-banks flag on precharge) |

## Verification
Self-refresh is exercised from three starting points. The first has a clean idle memory. The second has an open bank and a live burst, which separates the burst-stop, precharge and entry steps cycle by cycle. The third has power-down requested alongside. After each exit, the full recovery-and-refresh window is compared position by position, so a wrong refresh count or spacing shows up.

Power-down is held once for a short time, which shows that exit follows the request. It is held once past the cap, which shows the forced exit and the re-arm rule. Clock suspend is requested without a burst and then with one, which shows that the burst gates it. Suspend and power-down requested together, with suspend then dropped, tell the two states apart by whether CKE rises.

// File: rtl/lp_seq_pkg.sv
package lp_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_BST, ST_BST_WT, ST_PRE, ST_PRE_WT, ST_SR_HOLD,
    ST_SR_EXIT, ST_AREF, ST_AREF_WT, ST_PD_HOLD, ST_CS_HOLD, ST_RECOV
  } lp_state_e;

  // command encodings, {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_BST = 4'b0110;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;
endpackage

// File: rtl/lp_seq_ctl.sv
module lp_seq_ctl
  import lp_seq_pkg::*;
#(
  parameter int BANKS     = 2,
  parameter int T_CKA     = 4,
  parameter int T_RC      = 8,
  parameter int T_RP      = 3,
  parameter int CAS_LAT   = 3,
  parameter int REF_COUNT = 4096,
  parameter int T_REF_LIM = 100000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sr_req,
  input  logic             pd_req,
  input  logic             cs_req,
  input  logic             burst_active,
  input  logic [BANKS-1:0] bank_open,
  output lp_state_e        st_o
);
  localparam int M1   = (T_CKA > T_RC) ? T_CKA : T_RC;
  localparam int M2   = (T_RP > CAS_LAT) ? T_RP : CAS_LAT;
  localparam int M3   = (M1 > M2) ? M1 : M2;
  localparam int MAXV = (M3 > T_REF_LIM) ? M3 : T_REF_LIM;
  localparam int CW   = $clog2(MAXV + 1);
  localparam int RCW  = $clog2(REF_COUNT + 1);

  lp_state_e      st_q, st_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [RCW-1:0] rcnt_q, rcnt_d;
  logic           rearm_q, rearm_d;
  logic           cnt_en;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    rcnt_d  = rcnt_q;
    rearm_d = rearm_q;
    if (!pd_req && !cs_req) rearm_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (sr_req) begin
          if (burst_active)   st_d = ST_BST;
          else if (|bank_open) st_d = ST_PRE;
          else begin st_d = ST_SR_HOLD; rcnt_d = RCW'(REF_COUNT); end
        end else if (cs_req && burst_active && !rearm_q) begin
          st_d = ST_CS_HOLD; cnt_d = CW'(T_REF_LIM - 1);
        end else if (pd_req && !rearm_q) begin
          st_d = ST_PD_HOLD; cnt_d = CW'(T_REF_LIM - 1);
        end
      end
      ST_BST: begin st_d = ST_BST_WT; cnt_d = CW'(CAS_LAT - 1); end
      ST_BST_WT: begin
        if (cnt_q != '0) cnt_d = cnt_q - CW'(1);
        else if (|bank_open) st_d = ST_PRE;
        else begin st_d = ST_SR_HOLD; rcnt_d = RCW'(REF_COUNT); end
      end
      ST_PRE: begin st_d = ST_PRE_WT; cnt_d = CW'(T_RP - 1); end
      ST_PRE_WT: begin
        if (cnt_q != '0) cnt_d = cnt_q - CW'(1);
        else begin st_d = ST_SR_HOLD; rcnt_d = RCW'(REF_COUNT); end
      end
      ST_SR_HOLD: if (!sr_req) begin st_d = ST_SR_EXIT; cnt_d = CW'(T_CKA - 1); end
      ST_SR_EXIT: begin
        if (cnt_q != '0) cnt_d = cnt_q - CW'(1);
        else st_d = ST_AREF;
      end
      ST_AREF: begin
        st_d   = ST_AREF_WT;
        cnt_d  = CW'(T_RC - 1);
        rcnt_d = rcnt_q - RCW'(1);
      end
      ST_AREF_WT: begin
        if (cnt_q != '0) cnt_d = cnt_q - CW'(1);
        else if (rcnt_q == '0) st_d = ST_IDLE;
        else st_d = ST_AREF;
      end
      ST_PD_HOLD, ST_CS_HOLD: begin
        if ((st_q == ST_PD_HOLD) ? !pd_req : !cs_req) begin
          st_d = ST_RECOV; cnt_d = CW'(T_CKA - 1);
        end else if (cnt_q == '0) begin
          st_d = ST_RECOV; cnt_d = CW'(T_CKA - 1); rearm_d = 1'b1;
        end else cnt_d = cnt_q - CW'(1);
      end
      ST_RECOV: begin
        if (cnt_q != '0) cnt_d = cnt_q - CW'(1);
        else st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign cnt_en = (st_q != ST_IDLE) || (st_d != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      rcnt_q  <= '0;
      rearm_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      rearm_q <= rearm_d;
      if (cnt_en) begin
        cnt_q  <= cnt_d;
        rcnt_q <= rcnt_d;
      end
    end
  end

  assign st_o = st_q;

  // independent residency tally for the cap check
  logic [CW:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else if (st_q == ST_PD_HOLD || st_q == ST_CS_HOLD) run_q <= run_q + 1'b1;
    else run_q <= '0;
  end

  p_sr_banks_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SR_HOLD && $past(st_q) != ST_SR_HOLD)
      |-> ($past(st_q) == ST_PRE_WT || ~|$past(bank_open)));
  p_ref_budget_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_AREF) |-> (rcnt_q != '0));
  p_resid_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PD_HOLD || st_q == ST_CS_HOLD) |-> (run_q < (CW+1)'(T_REF_LIM)));
  p_rearm_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && rearm_q && (pd_req || cs_req))
      |=> (st_q != ST_PD_HOLD && st_q != ST_CS_HOLD));
  p_cs_needs_burst_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CS_HOLD && $past(st_q) == ST_IDLE) |-> $past(burst_active));
endmodule

// File: rtl/lp_seq_pins.sv
module lp_seq_pins
  import lp_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  lp_state_e st,
  input  logic [3:0] host_cmd,
  input  logic      host_a10,
  output logic      host_gnt,
  output logic      cke,
  output logic [3:0] cmd,
  output logic      a10
);
  always_comb begin
    host_gnt = 1'b0;
    cke      = 1'b1;
    cmd      = CMD_NOP;
    a10      = 1'b0;
    unique case (st)
      ST_IDLE: begin host_gnt = 1'b1; cmd = host_cmd; a10 = host_a10; end
      ST_BST:  cmd = CMD_BST;
      ST_PRE:  begin cmd = CMD_PRE; a10 = 1'b1; end
      ST_SR_HOLD: begin cke = 1'b0; cmd = CMD_REF; end
      ST_AREF: cmd = CMD_REF;
      ST_PD_HOLD, ST_CS_HOLD: cke = 1'b0;
      default: cmd = CMD_NOP;
    endcase
  end

  p_gnt_cke_r2: assert property (@(posedge clk) disable iff (!rst_n)
    host_gnt |-> cke);
  p_exit_nop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (cmd == CMD_NOP && !host_gnt));
endmodule

// File: rtl/lp_seq.sv
module lp_seq
  import lp_seq_pkg::*;
#(
  parameter int BANKS     = 2,
  parameter int T_CKA     = 4,
  parameter int T_RC      = 8,
  parameter int T_RP      = 3,
  parameter int CAS_LAT   = 3,
  parameter int REF_COUNT = 4096,
  parameter int T_REF_LIM = 100000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sr_req,
  input  logic             pd_req,
  input  logic             cs_req,
  input  logic             burst_active,
  input  logic [BANKS-1:0] bank_open,
  input  logic [3:0]       host_cmd,
  input  logic             host_a10,
  output logic             host_gnt,
  output logic             sd_cke,
  output logic             sd_cs_n,
  output logic             sd_ras_n,
  output logic             sd_cas_n,
  output logic             sd_we_n,
  output logic             sd_a10
);
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  lp_state_e  st;
  logic [3:0] cmd;

  lp_seq_ctl #(
    .BANKS(BANKS), .T_CKA(T_CKA), .T_RC(T_RC), .T_RP(T_RP),
    .CAS_LAT(CAS_LAT), .REF_COUNT(REF_COUNT), .T_REF_LIM(T_REF_LIM)
  ) u_ctl (
    .clk(clk), .rst_n(rst_sync), .sr_req(sr_req), .pd_req(pd_req),
    .cs_req(cs_req), .burst_active(burst_active), .bank_open(bank_open),
    .st_o(st)
  );

  lp_seq_pins u_pins (
    .clk(clk), .rst_n(rst_sync), .st(st), .host_cmd(host_cmd),
    .host_a10(host_a10), .host_gnt(host_gnt), .cke(sd_cke), .cmd(cmd),
    .a10(sd_a10)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
endmodule

// File: tb/sim_lp_seq.sv
`timescale 1ns/1ps
module sim_lp_seq;
  localparam int P_CKA = 3, P_RC = 2, P_RP = 2, P_CL = 2, P_REF = 5, P_LIM = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sr_req = 0, pd_req = 0, cs_req = 0, burst_active = 0;
  logic [1:0] bank_open = 2'b00;
  logic [3:0] host_cmd = 4'b0111;
  logic host_a10 = 1'b0;
  logic host_gnt, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_a10;
  logic [3:0] cmd;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;
  assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  lp_seq #(.BANKS(2), .T_CKA(P_CKA), .T_RC(P_RC), .T_RP(P_RP),
           .CAS_LAT(P_CL), .REF_COUNT(P_REF), .T_REF_LIM(P_LIM)) u0 (
    .clk(clk), .rst_n(rst_n), .sr_req(sr_req), .pd_req(pd_req),
    .cs_req(cs_req), .burst_active(burst_active), .bank_open(bank_open),
    .host_cmd(host_cmd), .host_a10(host_a10), .host_gnt(host_gnt),
    .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_a10(sd_a10));

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_gnt();
    for (int i = 0; i < 200; i++) begin
      if (host_gnt) break;
      tick();
    end
  endtask

  // window after self-refresh release: recovery then refresh sweep (R7, R8)
  task automatic exit_seq();
    int bad7 = 0, bad8 = 0;
    for (int k = 0; k < P_CKA + P_REF * (1 + P_RC); k++) begin
      tick();
      if (k < P_CKA) begin
        if (!sd_cke || host_gnt || cmd != 4'b0111) bad7++;
      end else begin
        logic [3:0] e;
        e = (((k - P_CKA) % (1 + P_RC)) == 0) ? 4'b0001 : 4'b0111;
        if (!sd_cke || host_gnt || cmd != e) bad8++;
      end
    end
    chk("R7 recovery window mismatches", bad7, 0);
    chk("R8 refresh sweep mismatches", bad8, 0);
    tick();
    chk("R8 grant after sweep", host_gnt, 1);
  endtask

  task automatic t_reset();
    tick();
    chk("R1 cke in reset", sd_cke, 1);
    chk("R1 gnt in reset", host_gnt, 1);
    rst_n = 1'b1;
    repeat (3) tick();
    chk("R1 cke after reset", sd_cke, 1);
    chk("R1 gnt after reset", host_gnt, 1);
  endtask

  task automatic t_pass();
    host_cmd = 4'b0011; host_a10 = 1'b1;
    tick();
    chk("R2 host cmd passes", cmd, 4'b0011);
    chk("R2 host a10 passes", sd_a10, 1);
    chk("R2 gnt idle", host_gnt, 1);
    host_cmd = 4'b0111; host_a10 = 1'b0;
  endtask

  task automatic t_sr_plain();
    int hi = 0;
    sr_req = 1;
    tick();
    chk("R3 cke low on entry", sd_cke, 0);
    chk("R3 entry command", cmd, 4'b0001);
    chk("R3 gnt drops", host_gnt, 0);
    repeat (5) begin tick(); if (sd_cke) hi++; end
    chk("R6 cke held low", hi, 0);
    sr_req = 0;
    exit_seq();
  endtask

  task automatic t_sr_full();
    bank_open = 2'b10; burst_active = 1; sr_req = 1;
    tick();
    chk("R5 burst stop", cmd, 4'b0110);
    tick(); chk("R5 cas wait 1", cmd, 4'b0111);
    tick(); chk("R5 cas wait 2", cmd, 4'b0111);
    tick();
    chk("R4 precharge all", cmd, 4'b0010);
    chk("R4 a10 set", sd_a10, 1);
    tick(); chk("R4 trp wait 1", cmd, 4'b0111);
    tick(); chk("R4 trp wait 2 cke", sd_cke, 1);
    tick();
    chk("R4 sr entry cke", sd_cke, 0);
    chk("R4 sr entry cmd", cmd, 4'b0001);
    bank_open = 2'b00; burst_active = 0; sr_req = 0;
    exit_seq();
  endtask

  task automatic t_pd();
    pd_req = 1;
    tick();
    chk("R9 pd cke low", sd_cke, 0);
    chk("R9 pd nop", cmd, 4'b0111);
    chk("R9 pd gnt low", host_gnt, 0);
    repeat (2) tick();
    pd_req = 0;
    tick();
    chk("R7 pd exit cke", sd_cke, 1);
    chk("R7 pd exit gnt", host_gnt, 0);
    repeat (2) tick();
    chk("R7 still recovering", host_gnt, 0);
    tick();
    chk("R9 gnt after recovery", host_gnt, 1);
  endtask

  task automatic t_pd_cap();
    int lows = 0, bad = 0;
    pd_req = 1;
    for (int i = 0; i < 20; i++) begin
      tick();
      if (sd_cke) break;
      lows++;
    end
    chk("R10 low cycles before forced exit", lows, P_LIM);
    repeat (P_CKA) tick();
    repeat (3) begin
      if (!sd_cke || !host_gnt) bad++;
      tick();
    end
    chk("R10 no re-entry while held", bad, 0);
    pd_req = 0;
    tick();
    pd_req = 1;
    tick();
    chk("R10 re-entry after re-arm", sd_cke, 0);
    pd_req = 0;
    tick();
    wait_gnt();
    chk("R10 back idle", host_gnt, 1);
  endtask

  task automatic t_cs();
    int bad = 0;
    burst_active = 0; cs_req = 1;
    repeat (3) begin tick(); if (!sd_cke || !host_gnt) bad++; end
    chk("R11 suspend ignored without burst", bad, 0);
    burst_active = 1;
    tick();
    chk("R11 suspend cke low", sd_cke, 0);
    chk("R11 suspend gnt low", host_gnt, 0);
    tick();
    cs_req = 0;
    tick();
    chk("R7 suspend exit cke", sd_cke, 1);
    burst_active = 0;
    wait_gnt();
    chk("R11 gnt restored", host_gnt, 1);
  endtask

  task automatic t_prio();
    sr_req = 1; pd_req = 1;
    tick();
    chk("R12 sr beats pd cmd", cmd, 4'b0001);
    chk("R12 sr beats pd cke", sd_cke, 0);
    sr_req = 0; pd_req = 0;
    exit_seq();
    burst_active = 1; cs_req = 1; pd_req = 1;
    tick();
    chk("R12 low state entered", sd_cke, 0);
    cs_req = 0;
    tick();
    chk("R12 suspend chosen over pd", sd_cke, 1);
    pd_req = 0; burst_active = 0;
    wait_gnt();
    chk("R12 idle again", host_gnt, 1);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_pass();
    t_sr_plain();
    t_sr_full();
    t_pd();
    t_pd_cap();
    t_cs();
    t_prio();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule